// File: doc/BRIEF.md
# Boot Stream Interpreter

This block turns a byte stream, read from a non-volatile boot device, into configuration actions before any processor runs. The bytes arrive on a ready/valid port in fetch order. In the first phase the block checks a two-byte preamble and a fixed header. It then stores a 64-byte configuration word in an internal register file. In the second phase it decodes a series of records. Each record carries a one-byte header, a 24-bit target address and one or more 32-bit data words. Each data word becomes a write on a simple request/acknowledge configuration bus, unless its address falls in a reserved command page.

The command page holds four operations:
- read back the last written location (flush),
- compare a running CRC-32,
- redirect the source fetch address (jump),
- idle for a number of clocks (wait).

A record with its continue bit clear closes the stream. That record must carry the checksum of everything that came before it. After a good end the block pulses done and may let the boot processor out of reset. Any format fault halts the block, raises a reset request and holds an error code.

Top module: `boot_stream_interp`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: in_ready is 1, reset_req, done, boot_release and bus_req are 0, and err_code is 0x00.
- R2: The first two stream bytes must both be 0xA5. If either byte differs, the block halts with err_code 0x70.
- R3: The configuration header byte is decoded as follows. If bit 7 (alternate-space flag) is 1, the code is 0x71. If bits 6:1 (length field) are not zero, the code is 0x72. The alternate-space flag is checked first. The 3-byte address that follows, most significant byte first, must equal 0x0E0100; otherwise the code is 0x74.
- R4: The 64 configuration bytes that follow are stored at indexes 0 to 63 in arrival order. Index cfg_idx is presented on cfg_byte one clock later.
- R5: A record header carries three fields:
  - bit 7 is the alternate-space flag,
  - bits 6:1 are the byte length, where 0 means 64,
  - bit 0 is the continue flag.
  The header is followed by a 3-byte address, most significant byte first. Data words are big-endian. Each word of a continuing record outside the command page gives one write (bus_we=1). The write carries the record's alternate flag, and the address grows by 4 for each word. A continuing record whose length is not a multiple of 4 halts the block with code 0x73.
- R6: A bus request holds bus_we, bus_alt, bus_addr and bus_wdata steady until bus_ack. Only one request is outstanding, and no byte is accepted while it is pending.
- R7: A word addressed to 0x138000 with the alternate flag clear issues a read (bus_we=0). The read goes to the address and alternate flag of the most recent write, and no write is made.
- R8: A word addressed to 0x138080 raises jump_req for one clock, with jump_addr equal to the data word. It causes no bus request.
- R9: A word addressed to 0x1380C0 with value N holds in_ready low for exactly N+1 clocks after its last byte.
- R10: The checksum is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. It is shifted most significant bit first, with no final inversion. A word addressed to 0x138040 in a continuing record must equal the CRC of all stream bytes before that word; a mismatch halts the block with code 0x7B.
- R11: A record with the continue flag clear must have header 0x08 and address 0x138040; otherwise the code is 0x79. Its data word must equal the CRC of all bytes before it; otherwise the code is 0x7B. A match pulses done for one clock, after which no byte is accepted.
- R12: boot_release goes high together with done when bit 7 of configuration byte 8 is 0. It stays low when that bit is 1.
- R13: After an error, the following hold until reset: reset_req stays 1, err_code stays unchanged, in_ready stays 0 and no bus request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte this clock |
| bus_req | output | 1 | Configuration bus request |
| bus_we | output | 1 | 1 write, 0 read-back |
| bus_alt | output | 1 | Target is the alternate space |
| bus_addr | output | 24 | Offset in the 16 MB space |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Request completed |
| jump_req | output | 1 | One-clock fetch redirect pulse |
| jump_addr | output | SRC_AW | New source fetch address |
| cfg_idx | input | 6 | Configuration byte index to read |
| cfg_byte | output | 8 | Configuration byte, one clock after cfg_idx |
| err_code | output | 8 | Held error code, 0 when no error |
| reset_req | output | 1 | Reset request after an error |
| done | output | 1 | One-clock pulse after a good end record |
| boot_release | output | 1 | Boot processor may start |

## Verification
The bench builds the block with its default parameters: SRC_AW of 32 and WAIT_W of 16. With these values a full 32-bit jump target passes through unchanged, and a wait count wider than a byte is accepted. Small wait counts keep the exact N+1 stall window observable per byte. Each error code is reached by corrupting exactly one field, so each failing test checks that the first violated rule wins and that the halt is permanent.

// File: rtl/bsi_pkg.sv
package bsi_pkg;
  localparam int CFG_BYTES = 64;
  localparam int CFG_IW    = $clog2(CFG_BYTES);
  localparam int HOLD_IDX  = 8;
  localparam int HOLD_BIT  = 7;

  localparam logic [7:0]  PRE_BYTE  = 8'hA5;
  localparam logic [23:0] CFG_ADDR  = 24'h0E0100;
  localparam logic [15:0] CMD_PAGE  = 16'h1380;
  localparam logic [7:0]  CMD_FLUSH = 8'h00;
  localparam logic [7:0]  CMD_CRC   = 8'h40;
  localparam logic [7:0]  CMD_JUMP  = 8'h80;
  localparam logic [7:0]  CMD_WAIT  = 8'hC0;
  localparam logic [7:0]  END_HDR   = 8'h08;
  localparam logic [23:0] END_ADDR  = 24'h138040;

  localparam logic [7:0] ERR_PREAMBLE = 8'h70;
  localparam logic [7:0] ERR_CFG_ALT  = 8'h71;
  localparam logic [7:0] ERR_CFG_LEN  = 8'h72;
  localparam logic [7:0] ERR_ALIGN    = 8'h73;
  localparam logic [7:0] ERR_CFG_ADDR = 8'h74;
  localparam logic [7:0] ERR_END      = 8'h79;
  localparam logic [7:0] ERR_CRC      = 8'h7B;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef enum logic [3:0] {
    ST_PRE0, ST_PRE1, ST_CHDR, ST_CADR, ST_CDAT,
    ST_HDR, ST_ADR, ST_DAT, ST_BUS, ST_WAIT, ST_DONE, ST_HALT
  } st_t;

  // Length field of a record header, 0 encodes the full 64 bytes.
  function automatic logic [6:0] rec_len(input logic [7:0] h);
    return (h[6:1] == 6'd0) ? 7'(CFG_BYTES) : {1'b0, h[6:1]};
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/bsi_crc32.sv
module bsi_crc32
  import bsi_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  always_ff @(posedge clk) begin
    if (rst)     crc <= CRC_INIT;
    else if (en) crc <= crc_step(crc, din);
  end

  // R10: the running checksum only moves on accepted bytes
  p_crc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(crc));
endmodule

// File: rtl/bsi_cfg_store.sv
module bsi_cfg_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/boot_stream_interp.sv
module boot_stream_interp
  import bsi_pkg::*;
#(
  parameter int SRC_AW = 32,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_alt,
  output logic [23:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  output logic              jump_req,
  output logic [SRC_AW-1:0] jump_addr,
  input  logic [CFG_IW-1:0] cfg_idx,
  output logic [7:0]        cfg_byte,
  output logic [7:0]        err_code,
  output logic              reset_req,
  output logic              done,
  output logic              boot_release
);
  st_t               state;
  st_t               after_word;
  logic [6:0]        cnt;
  logic [7:0]        hdr;
  logic [23:0]       addr, last_addr, addr_n;
  logic              last_alt, hold_bit;
  logic [23:0]       word;
  logic [31:0]       word_n, crc, crc_mark;
  logic [WAIT_W-1:0] wcnt;
  logic              acc, is_cmd;

  assign in_ready   = state inside {ST_PRE0, ST_PRE1, ST_CHDR, ST_CADR,
                                    ST_CDAT, ST_HDR, ST_ADR, ST_DAT};
  assign acc        = in_valid && in_ready;
  assign addr_n     = {addr[15:0], in_data};
  assign word_n     = {word, in_data};
  assign is_cmd     = !hdr[7] && (addr[23:8] == CMD_PAGE);
  assign after_word = (cnt == 7'd1) ? ST_HDR : ST_DAT;

  bsi_crc32 u_crc (
    .clk (clk), .rst (rst), .en (acc), .din (in_data), .crc (crc)
  );

  bsi_cfg_store #(.DEPTH(CFG_BYTES), .W(8)) u_cfg (
    .clk   (clk),
    .we    (acc && (state == ST_CDAT)),
    .waddr (cnt[CFG_IW-1:0]),
    .wdata (in_data),
    .raddr (cfg_idx),
    .rdata (cfg_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_PRE0;       cnt <= '0;          hdr <= '0;
      addr <= '0;             last_addr <= '0;    last_alt <= 1'b0;
      hold_bit <= 1'b0;       word <= '0;         crc_mark <= CRC_INIT;
      wcnt <= '0;             bus_req <= 1'b0;    bus_we <= 1'b0;
      bus_alt <= 1'b0;        bus_addr <= '0;     bus_wdata <= '0;
      jump_req <= 1'b0;       jump_addr <= '0;    err_code <= '0;
      reset_req <= 1'b0;      done <= 1'b0;       boot_release <= 1'b0;
    end else begin
      done     <= 1'b0;
      jump_req <= 1'b0;
      case (state)
        ST_PRE0, ST_PRE1: if (acc) begin
          if (in_data != PRE_BYTE) begin
            err_code <= ERR_PREAMBLE; reset_req <= 1'b1; state <= ST_HALT;
          end else begin
            state <= (state == ST_PRE0) ? ST_PRE1 : ST_CHDR;
          end
        end
        ST_CHDR: if (acc) begin
          hdr <= in_data;
          cnt <= '0;
          if (in_data[7]) begin
            err_code <= ERR_CFG_ALT; reset_req <= 1'b1; state <= ST_HALT;
          end else if (in_data[6:1] != 6'd0) begin
            err_code <= ERR_CFG_LEN; reset_req <= 1'b1; state <= ST_HALT;
          end else begin
            state <= ST_CADR;
          end
        end
        ST_CADR: if (acc) begin
          addr <= addr_n;
          cnt  <= cnt + 7'd1;
          if (cnt == 7'd2) begin
            if (addr_n != CFG_ADDR) begin
              err_code <= ERR_CFG_ADDR; reset_req <= 1'b1; state <= ST_HALT;
            end else begin
              state <= ST_CDAT;
              cnt   <= '0;
            end
          end
        end
        ST_CDAT: if (acc) begin
          if (cnt == 7'(HOLD_IDX)) hold_bit <= in_data[HOLD_BIT];
          cnt <= cnt + 7'd1;
          if (cnt == 7'(CFG_BYTES - 1)) state <= ST_HDR;
        end
        ST_HDR: if (acc) begin
          hdr <= in_data;
          cnt <= '0;
          if (in_data[0] && (in_data[2:1] != 2'b00)) begin
            err_code <= ERR_ALIGN; reset_req <= 1'b1; state <= ST_HALT;
          end else begin
            state <= ST_ADR;
          end
        end
        ST_ADR: if (acc) begin
          addr <= addr_n;
          cnt  <= cnt + 7'd1;
          if (cnt == 7'd2) begin
            if (!hdr[0] && ((hdr != END_HDR) || (addr_n != END_ADDR))) begin
              err_code <= ERR_END; reset_req <= 1'b1; state <= ST_HALT;
            end else begin
              state <= ST_DAT;
              cnt   <= rec_len(hdr);
            end
          end
        end
        ST_DAT: if (acc) begin
          word <= word_n[23:0];
          cnt  <= cnt - 7'd1;
          if (cnt[1:0] == 2'd0) crc_mark <= crc;  // first byte of a word
          if (cnt[1:0] == 2'd1) begin             // last byte of a word
            if (!hdr[0]) begin
              if (word_n == crc_mark) begin
                done <= 1'b1; boot_release <= !hold_bit; state <= ST_DONE;
              end else begin
                err_code <= ERR_CRC; reset_req <= 1'b1; state <= ST_HALT;
              end
            end else if (is_cmd) begin
              case (addr[7:0])
                CMD_FLUSH: begin
                  bus_req <= 1'b1; bus_we <= 1'b0; bus_alt <= last_alt;
                  bus_addr <= last_addr; state <= ST_BUS;
                end
                CMD_CRC: begin
                  if (word_n != crc_mark) begin
                    err_code <= ERR_CRC; reset_req <= 1'b1; state <= ST_HALT;
                  end else begin
                    state <= after_word;
                  end
                end
                CMD_JUMP: begin
                  jump_req <= 1'b1; jump_addr <= word_n[SRC_AW-1:0];
                  state <= after_word;
                end
                CMD_WAIT: begin
                  wcnt <= word_n[WAIT_W-1:0]; state <= ST_WAIT;
                end
                default: state <= after_word;
              endcase
            end else begin
              bus_req <= 1'b1; bus_we <= 1'b1; bus_alt <= hdr[7];
              bus_addr <= addr; bus_wdata <= word_n;
              last_addr <= addr; last_alt <= hdr[7];
              addr <= addr + 24'd4;
              state <= ST_BUS;
            end
          end
        end
        ST_BUS: if (bus_ack) begin
          bus_req <= 1'b0;
          state   <= (cnt == 7'd0) ? ST_HDR : ST_DAT;
        end
        ST_WAIT: begin
          if (wcnt == '0) state <= (cnt == 7'd0) ? ST_HDR : ST_DAT;
          else            wcnt  <= wcnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6: request fields frozen until acknowledged
  p_bus_hold_r6: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                            && $stable(bus_we) && $stable(bus_alt));
  // R6: no byte accepted while a request is pending
  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !in_ready);
  // R13: a halt is permanent
  p_halt_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req && $stable(err_code) && !in_ready && !bus_req);
  // R11: done is a single pulse and closes the input
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !in_ready);
  // R12: release only rises together with done
  p_release_with_done_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_release) |-> done);
  // R8: jump is a one-clock pulse
  p_jump_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    jump_req |=> !jump_req);
endmodule

// File: tb/tb_boot_stream_interp.sv
module tb_boot_stream_interp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        bus_req, bus_we, bus_alt;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic        jump_req;
  logic [31:0] jump_addr;
  logic [5:0]  cfg_idx = 6'd0;
  logic [7:0]  cfg_byte;
  logic [7:0]  err_code;
  logic        reset_req, done, boot_release;

  always #4 clk = ~clk;

  boot_stream_interp dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_alt(bus_alt), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .jump_req(jump_req), .jump_addr(jump_addr),
    .cfg_idx(cfg_idx), .cfg_byte(cfg_byte), .err_code(err_code), .reset_req(reset_req),
    .done(done), .boot_release(boot_release)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int done_cnt = 0;
  int stall_log [512];
  logic [7:0]  sq [$];
  logic [57:0] bus_log [$];
  logic [31:0] jump_log [$];

  // {header, address, data} write records
  localparam logic [63:0] VEC [6] = '{
    64'h09_000010_00000000, 64'h89_000014_81D00000, 64'h09_021008_0000F000,
    64'h89_021028_0000F000, 64'h09_FFFFFC_12345678, 64'h89_000000_DEADBEEF
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // bus responder and event recorder
  always @(negedge clk) begin
    if (rst) bus_ack = 1'b0;
    else if (bus_req && !bus_ack) begin
      bus_log.push_back({bus_we, bus_alt, bus_addr, bus_wdata});
      bus_ack = 1'b1;
    end else bus_ack = 1'b0;
    if (!rst && jump_req) jump_log.push_back(jump_addr);
    if (!rst && done) done_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[31] ^ sq[k][b];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  function automatic logic [7:0] cfgv(input int i, input bit hold);
    if (i == 8) return hold ? 8'h80 : 8'h11;
    return 8'(i * 37 + 5);
  endfunction

  task automatic add_word(input logic [31:0] w);
    sq.push_back(w[31:24]); sq.push_back(w[23:16]);
    sq.push_back(w[15:8]);  sq.push_back(w[7:0]);
  endtask

  task automatic add_hdr(input logic [7:0] h, input logic [23:0] a);
    sq.push_back(h); sq.push_back(a[23:16]); sq.push_back(a[15:8]); sq.push_back(a[7:0]);
  endtask

  task automatic add_cfg(input bit hold);
    sq.delete();
    sq.push_back(8'hA5); sq.push_back(8'hA5);
    add_hdr(8'h01, 24'h0E0100);
    for (int i = 0; i < 64; i++) sq.push_back(cfgv(i, hold));
  endtask

  task automatic add_crc_rec(input logic [7:0] h, input logic [31:0] flip);
    add_hdr(h, 24'h138040);
    add_word(crc_of(sq.size()) ^ flip);
  endtask

  task automatic reset_dut();
    in_valid = 1'b0;
    rst = 1'b1;
    bus_log.delete(); jump_log.delete(); done_cnt = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int idx);
    int stall = 0;
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      if (in_ready) begin @(negedge clk); break; end
      if (reset_req || done_cnt != 0 || stall > 2000) break;
      stall++;
      @(negedge clk);
    end
    stall_log[idx] = stall;
  endtask

  task automatic run_stream();
    reset_dut();
    foreach (sq[i]) begin
      if (reset_req || done_cnt != 0) break;
      send_byte(sq[i], i);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_err(input string tag, input logic [7:0] code);
    run_stream();
    chk({tag, " err_code"}, err_code, code);
    chk({tag, " reset_req"}, reset_req, 1'b1);
    chk({tag, " no done"}, done_cnt, 0);
  endtask

  task automatic rd_cfg(input int idx, output logic [7:0] v);
    cfg_idx = 6'(idx);
    @(negedge clk);
    v = cfg_byte;
  endtask

  initial begin
    logic [7:0] v;
    int pos, nlog;

    // R1 reset state
    reset_dut();
    chk("R1 in_ready", in_ready, 1'b1);
    chk("R1 reset_req", reset_req, 1'b0);
    chk("R1 err_code", err_code, 8'h00);
    chk("R1 done/release/bus", {done, boot_release, bus_req}, 3'b000);

    // vector table: R5 writes, R11 good end, R12 release, R4 readback
    add_cfg(1'b0);
    foreach (VEC[i]) begin
      add_hdr(VEC[i][63:56], VEC[i][55:32]);
      add_word(VEC[i][31:0]);
    end
    add_crc_rec(8'h08, 32'h0);
    run_stream();
    chk("R5 write count", bus_log.size(), 6);
    foreach (VEC[i])
      if (i < bus_log.size())
        chk("R5 write fields", bus_log[i], {1'b1, VEC[i][63], VEC[i][55:32], VEC[i][31:0]});
    chk("R11 done pulse", done_cnt, 1);
    chk("R11 err_code clear", err_code, 8'h00);
    chk("R11 input closed", in_ready, 1'b0);
    chk("R12 release hold=0", boot_release, 1'b1);
    foreach (VEC[i]) begin
      int idx = (i * 11) % 64;
      rd_cfg(idx, v);
      chk("R4 cfg byte", v, cfgv(idx, 1'b0));
    end
    rd_cfg(63, v); chk("R4 cfg last byte", v, cfgv(63, 1'b0));

    // R5 multi-word record, address steps by 4
    add_cfg(1'b0);
    add_hdr(8'h11, 24'h000100);
    add_word(32'hA1A2A3A4); add_word(32'hB1B2B3B4);
    add_crc_rec(8'h08, 32'h0);
    run_stream();
    chk("R5 two words", bus_log.size(), 2);
    if (bus_log.size() == 2) begin
      chk("R5 word0", bus_log[0], {1'b1, 1'b0, 24'h000100, 32'hA1A2A3A4});
      chk("R5 word1", bus_log[1], {1'b1, 1'b0, 24'h000104, 32'hB1B2B3B4});
    end

    // R7 flush reads back last write
    add_cfg(1'b0);
    add_hdr(8'h89, 24'h000200); add_word(32'h00000005);
    add_hdr(8'h09, 24'h138000); add_word(32'h00000000);
    add_crc_rec(8'h08, 32'h0);
    run_stream();
    chk("R7 bus count", bus_log.size(), 2);
    if (bus_log.size() == 2)
      chk("R7 flush read", bus_log[1][57:32], {1'b0, 1'b1, 24'h000200});
    chk("R7 done", done_cnt, 1);

    // R8 jump
    add_cfg(1'b0);
    add_hdr(8'h09, 24'h138080); add_word(32'hC0400000);
    add_crc_rec(8'h08, 32'h0);
    run_stream();
    chk("R8 one jump", jump_log.size(), 1);
    if (jump_log.size() == 1) chk("R8 jump addr", jump_log[0], 32'hC0400000);
    chk("R8 no bus", bus_log.size(), 0);

    // R9 wait N=5, and R12 hold-off set
    add_cfg(1'b1);
    add_hdr(8'h09, 24'h1380C0); add_word(32'h00000005);
    pos = sq.size();
    add_crc_rec(8'h08, 32'h0);
    run_stream();
    chk("R9 stall N+1", stall_log[pos], 6);
    chk("R12 done with hold", done_cnt, 1);
    chk("R12 release held", boot_release, 1'b0);

    // R9 wait N=0
    add_cfg(1'b0);
    add_hdr(8'h09, 24'h1380C0); add_word(32'h00000000);
    pos = sq.size();
    add_crc_rec(8'h08, 32'h0);
    run_stream();
    chk("R9 stall N=0", stall_log[pos], 1);

    // R10 mid-stream CRC good
    add_cfg(1'b0);
    add_hdr(8'h09, 24'h0000C0); add_word(32'h01020304);
    add_crc_rec(8'h09, 32'h0);
    add_crc_rec(8'h08, 32'h0);
    run_stream();
    chk("R10 good check done", done_cnt, 1);
    chk("R10 good check err", err_code, 8'h00);

    // R10 mid-stream CRC bad, then R13 halt behaviour
    add_cfg(1'b0);
    add_hdr(8'h09, 24'h0000C0); add_word(32'h01020304);
    add_crc_rec(8'h09, 32'h00000100);
    add_hdr(8'h09, 24'h000300); add_word(32'h77777777);
    add_crc_rec(8'h08, 32'h0);
    expect_err("R10 bad check", 8'h7B);
    nlog = bus_log.size();
    repeat (20) @(negedge clk);
    chk("R13 reset_req held", reset_req, 1'b1);
    chk("R13 err_code held", err_code, 8'h7B);
    chk("R13 input closed", in_ready, 1'b0);
    chk("R13 no bus after error", bus_log.size(), nlog);
    chk("R13 only pre-error write", nlog, 1);

    // R11 end record errors
    add_cfg(1'b0);
    add_crc_rec(8'h08, 32'h80000000);
    expect_err("R11 bad end crc", 8'h7B);
    add_cfg(1'b0);
    add_hdr(8'h0A, 24'h138040); add_word(32'h0);
    expect_err("R11 bad end header", 8'h79);
    add_cfg(1'b0);
    add_hdr(8'h08, 24'h138044); add_word(32'h0);
    expect_err("R11 bad end address", 8'h79);

    // R2 preamble
    sq.delete(); sq.push_back(8'hA5); sq.push_back(8'h5A);
    expect_err("R2 second preamble byte", 8'h70);
    sq.delete(); sq.push_back(8'h00); sq.push_back(8'hA5);
    expect_err("R2 first preamble byte", 8'h70);

    // R3 configuration header
    sq.delete(); sq.push_back(8'hA5); sq.push_back(8'hA5); sq.push_back(8'h83);
    expect_err("R3 alt flag first", 8'h71);
    sq.delete(); sq.push_back(8'hA5); sq.push_back(8'hA5); sq.push_back(8'h03);
    expect_err("R3 length field", 8'h72);
    sq.delete(); sq.push_back(8'hA5); sq.push_back(8'hA5);
    add_hdr(8'h01, 24'h0E0101);
    expect_err("R3 address", 8'h74);

    // R5 misaligned length
    add_cfg(1'b0);
    add_hdr(8'h0D, 24'h000400); add_word(32'h0);
    expect_err("R5 length not x4", 8'h73);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule